// File: doc/BRIEF.md
# I/O-Mode Single-Channel DMA Controller

This block is one DMA channel that moves data between a memory location and a fixed peripheral location. Each accepted transfer request moves exactly one unit, either a byte or a 16-bit word. The channel stops after a programmed number of transfers. The memory endpoint is a 24-bit address that steps forward or backward after each transfer. The peripheral endpoint is an 8-bit register padded with all-ones upper bits, and it never moves.

Each request arrives tagged with its activation source. Requests from the serial receive-data-full source copy from the peripheral location into memory. Requests from any other source copy from memory to the peripheral location. Each transfer runs as a read bus cycle and then a write bus cycle through an internal holding register. Both cycles wait for a ready acknowledge from the bus.

Software programs the channel through a small register write port: the memory address, the peripheral address byte, the transfer count and a control word. The channel reports the end of its work with a one-cycle done pulse.

Top module: `iodma_channel`

## Requirements
- R1: One accepted request causes exactly one read cycle and one write cycle. Control bit 1 selects the unit size (1 = 16-bit word, 0 = byte). In byte mode `bus_wdata[15:8]` is zero and `bus_wdata[7:0]` is the low byte read. In word mode all 16 read bits are written.
- R2: After each completed transfer the memory address moves by 1 (byte) or 2 (word). Control bit 2 selects the direction (0 = increment, 1 = decrement). The address wraps modulo 2^24.
- R3: The peripheral-side bus address is {16'hFFFF, io_byte}. Transfers never modify the peripheral address register.
- R4: A request whose `req_src` equals 1 (serial receive full) reads from the peripheral address and writes to the memory address.
- R5: A request with any other `req_src` value (0, 2, 3) reads from the memory address and writes to the peripheral address.
- R6: The remaining count drops by one per completed transfer. When it reaches zero, control bit 0 (enable) clears and `done` is high for exactly one cycle.
- R7: With enable clear, or with the remaining count zero, requests cause no bus cycle and change no state.
- R8: A request that arrives while a transfer is in progress is held and serviced afterwards. At most one request is held; further requests in the same busy period are dropped.
- R9: `bus_rd` and `bus_wr` are never high together. Each stays high with a stable address until `bus_ready` is seen.
- R10: In word mode an odd memory address sets `err` and performs no transfer, leaving the count and address unchanged. Any control write clears `err`.

Register select codes on `cfg_sel`: 0 = memory address (24 bits), 1 = peripheral address byte, 2 = transfer count (16 bits), 3 = control (bit0 enable, bit1 word, bit2 decrement).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 24 | Register write data |
| req_valid | input | 1 | Transfer request |
| req_src | input | 2 | Activation source of the request |
| bus_rd | output | 1 | Read cycle active |
| bus_wr | output | 1 | Write cycle active |
| bus_addr | output | 24 | Bus address |
| bus_word | output | 1 | Cycle is 16-bit |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Cycle acknowledge |
| done | output | 1 | One-cycle end-of-count pulse |
| err | output | 1 | Odd word address error flag |
| ch_en | output | 1 | Channel enable state |
| remaining | output | 16 | Remaining transfer count |
| mem_addr | output | 24 | Current memory address |

## Verification
The bench builds the channel with its default parameters: a 24-bit address, a 16-bit data path, 8-bit peripheral addressing and a 2-bit source tag with code 1 as the receive source. This lets all four source codes be tried, so both transfer directions are covered. A decrement from address zero reaches the 24-bit wrap. The bench bus model inserts two wait states on every cycle. Those stalls open a window in which further requests arrive during a busy transfer, so single-request holding and the dropping of extra requests are exercised.

// File: rtl/iodma_pkg.sv
package iodma_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RD   = 2'd1,
        SEQ_WR   = 2'd2
    } seq_state_e;

    localparam logic [1:0] SEL_MADDR = 2'd0;
    localparam logic [1:0] SEL_IO    = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_CTRL  = 2'd3;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_WORD_BIT = 1;
    localparam int CTRL_DEC_BIT  = 2;
endpackage

// File: rtl/iodma_regs.sv
module iodma_regs
    import iodma_pkg::*;
#(
    parameter int AW  = 24,
    parameter int IOW = 8,
    parameter int CW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          step_i,
    input  logic          err_set_i,
    output logic [AW-1:0] maddr_o,
    output logic [IOW-1:0] io_lo_o,
    output logic [CW-1:0] cnt_o,
    output logic          en_o,
    output logic          word_o,
    output logic          dec_o,
    output logic          err_o,
    output logic          done_o
);
    typedef struct packed {
        logic [AW-1:0]  maddr;
        logic [IOW-1:0] io_lo;
        logic [CW-1:0]  cnt;
        logic           en;
        logic           word;
        logic           dec;
        logic           err;
        logic           done;
    } regs_t;

    regs_t r_d, r_q;
    logic [AW-1:0] stride;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        stride   = {{(AW-2){1'b0}}, r_q.word, ~r_q.word};
        if (cfg_we) begin
            unique case (cfg_sel)
                SEL_MADDR: r_d.maddr = cfg_wdata;
                SEL_IO:    r_d.io_lo = cfg_wdata[IOW-1:0];
                SEL_COUNT: r_d.cnt   = cfg_wdata[CW-1:0];
                SEL_CTRL: begin
                    r_d.en   = cfg_wdata[CTRL_EN_BIT];
                    r_d.word = cfg_wdata[CTRL_WORD_BIT];
                    r_d.dec  = cfg_wdata[CTRL_DEC_BIT];
                    r_d.err  = 1'b0;
                end
                default: ;
            endcase
        end
        if (err_set_i) r_d.err = 1'b1;
        if (step_i) begin
            r_d.maddr = r_q.dec ? (r_q.maddr - stride) : (r_q.maddr + stride);
            r_d.cnt   = r_q.cnt - 1'b1;
            if (r_q.cnt == {{(CW-1){1'b0}}, 1'b1}) begin
                r_d.en   = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign maddr_o = r_q.maddr;
    assign io_lo_o = r_q.io_lo;
    assign cnt_o   = r_q.cnt;
    assign en_o    = r_q.en;
    assign word_o  = r_q.word;
    assign dec_o   = r_q.dec;
    assign err_o   = r_q.err;
    assign done_o  = r_q.done;

    assert_io_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == SEL_IO) |=> $stable(io_lo_o));
    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> cnt_o == $past(cnt_o) - 1'b1);
    assert_done_clears_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !en_o);
    assert_byte_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !word_o && !dec_o) |=> maddr_o == $past(maddr_o) + 1'b1);
endmodule

// File: rtl/iodma_seq.sv
module iodma_seq
    import iodma_pkg::*;
#(
    parameter int AW     = 24,
    parameter int DW     = 16,
    parameter int IOW    = 8,
    parameter int SRC_W  = 2,
    parameter int RX_SRC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cnt_nz_i,
    input  logic             word_i,
    input  logic [AW-1:0]    maddr_i,
    input  logic [IOW-1:0]   io_lo_i,
    input  logic             req_valid,
    input  logic [SRC_W-1:0] req_src,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ready,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    output logic             step_o,
    output logic             err_o
);
    localparam int UPPER = AW - IOW;
    localparam int HALF  = DW / 2;

    typedef struct packed {
        seq_state_e       state;
        logic             to_mem;
        logic [DW-1:0]    hold;
        logic             pend;
        logic [SRC_W-1:0] pend_src;
    } seq_t;

    seq_t s_d, s_q;
    logic [SRC_W-1:0] pick_src;
    logic [AW-1:0]    io_addr;

    assign io_addr = {{UPPER{1'b1}}, io_lo_i};

    always_comb begin
        s_d      = s_q;
        step_o   = 1'b0;
        err_o    = 1'b0;
        pick_src = s_q.pend ? s_q.pend_src : req_src;
        unique case (s_q.state)
            SEQ_IDLE: begin
                if (!en_i || !cnt_nz_i) begin
                    s_d.pend = 1'b0;
                end else if (req_valid || s_q.pend) begin
                    s_d.pend = 1'b0;
                    if (word_i && maddr_i[0]) begin
                        err_o = 1'b1;
                    end else begin
                        s_d.state  = SEQ_RD;
                        s_d.to_mem = (pick_src == SRC_W'(RX_SRC));
                    end
                end
            end
            SEQ_RD: begin
                if (bus_ready) begin
                    s_d.hold  = bus_rdata;
                    s_d.state = SEQ_WR;
                end
            end
            SEQ_WR: begin
                if (bus_ready) begin
                    step_o    = 1'b1;
                    s_d.state = SEQ_IDLE;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
        if (s_q.state != SEQ_IDLE && req_valid && !s_q.pend) begin
            s_d.pend     = 1'b1;
            s_d.pend_src = req_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: SEQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rd    = (s_q.state == SEQ_RD);
        bus_wr    = (s_q.state == SEQ_WR);
        bus_addr  = '0;
        if (bus_rd) bus_addr = s_q.to_mem ? io_addr : maddr_i;
        if (bus_wr) bus_addr = s_q.to_mem ? maddr_i : io_addr;
        bus_wdata = word_i ? s_q.hold : {{(DW-HALF){1'b0}}, s_q.hold[HALF-1:0]};
    end

    assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    assert_rd_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));
    assert_wr_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr)));
    assert_io_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_addr == maddr_i || bus_addr[AW-1:IOW] == {UPPER{1'b1}}));
    assert_idle_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == SEQ_IDLE && !en_i) |=> !bus_rd);
    assert_err_no_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !bus_rd);
endmodule

// File: rtl/iodma_channel.sv
module iodma_channel
    import iodma_pkg::*;
#(
    parameter int AW     = 24,
    parameter int DW     = 16,
    parameter int IOW    = 8,
    parameter int CW     = 16,
    parameter int SRC_W  = 2,
    parameter int RX_SRC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             req_valid,
    input  logic [SRC_W-1:0] req_src,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_word,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ready,
    output logic             done,
    output logic             err,
    output logic             ch_en,
    output logic [CW-1:0]    remaining,
    output logic [AW-1:0]    mem_addr
);
    logic           step, err_set, word, dec;
    logic [IOW-1:0] io_lo;

    iodma_regs #(.AW(AW), .IOW(IOW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .step_i    (step),
        .err_set_i (err_set),
        .maddr_o   (mem_addr),
        .io_lo_o   (io_lo),
        .cnt_o     (remaining),
        .en_o      (ch_en),
        .word_o    (word),
        .dec_o     (dec),
        .err_o     (err),
        .done_o    (done)
    );

    iodma_seq #(.AW(AW), .DW(DW), .IOW(IOW), .SRC_W(SRC_W), .RX_SRC(RX_SRC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (ch_en),
        .cnt_nz_i  (remaining != '0),
        .word_i    (word),
        .maddr_i   (mem_addr),
        .io_lo_i   (io_lo),
        .req_valid (req_valid),
        .req_src   (req_src),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .step_o    (step),
        .err_o     (err_set)
    );

    assign bus_word = word;

    assert_dec_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dec && !word) |=> mem_addr == $past(mem_addr) - 1'b1);
endmodule

// File: tb/test_iodma_channel.sv
module test_iodma_channel;
    localparam int WAITS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [23:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_src = '0;
    logic        bus_rd, bus_wr, bus_word, bus_ready;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        done, err, ch_en;
    logic [15:0] remaining;
    logic [23:0] mem_addr;

    int n_chk = 0;
    int n_bad = 0;
    int wait_cnt = 0;
    int wr_count = 0;
    int done_cycles = 0;
    logic [23:0] last_rd_addr = '0;
    logic [23:0] last_wr_addr = '0;
    logic [15:0] last_wr_data = '0;

    always #2.5 clk = ~clk;

    iodma_channel i_iodma_channel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_src(req_src),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .done(done), .err(err), .ch_en(ch_en), .remaining(remaining), .mem_addr(mem_addr)
    );

    function automatic logic [15:0] rmodel(input logic [23:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'h96};
    endfunction

    assign bus_ready = (bus_rd || bus_wr) && (wait_cnt == WAITS);
    assign bus_rdata = rmodel(bus_addr);

    always @(posedge clk) begin
        if ((bus_rd || bus_wr) && !bus_ready) wait_cnt <= wait_cnt + 1;
        else                                  wait_cnt <= 0;
        if (bus_rd && bus_ready) last_rd_addr <= bus_addr;
        if (bus_wr && bus_ready) begin
            last_wr_addr <= bus_addr;
            last_wr_data <= bus_wdata;
            wr_count     <= wr_count + 1;
        end
    end

    always @(negedge clk) if (done) done_cycles <= done_cycles + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [23:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req(input logic [1:0] src);
        @(negedge clk);
        req_valid = 1'b1; req_src = src;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  src;
        logic        word;
        logic        dec;
        logic [23:0] ma;
        logic [7:0]  io;
        logic [23:0] nxt;
    } vec_t;

    localparam logic [59:0] VECS [6] = '{
        {2'd0, 1'b0, 1'b0, 24'h001000, 8'h40, 24'h001001},
        {2'd1, 1'b0, 1'b0, 24'h002000, 8'h41, 24'h002001},
        {2'd2, 1'b1, 1'b0, 24'h003002, 8'h10, 24'h003004},
        {2'd1, 1'b1, 1'b1, 24'h004000, 8'h20, 24'h003FFE},
        {2'd3, 1'b0, 1'b1, 24'h000000, 8'hFF, 24'hFFFFFF},
        {2'd1, 1'b0, 1'b1, 24'h123457, 8'h00, 24'h123456}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int wr0, dc0;
        vec_t v;
        logic [23:0] io_full, exp_rd, exp_wr;
        logic [15:0] exp_data;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R9 reset bus_rd", bus_rd, 0);
        chk("R9 reset bus_wr", bus_wr, 0);
        chk("R6 reset done", done, 0);
        chk("R6 reset ch_en", ch_en, 0);
        chk("R10 reset err", err, 0);
        chk("R6 reset remaining", remaining, 0);

        // vector table: single transfers, direction, size, stride
        for (int i = 0; i < 6; i++) begin
            v = vec_t'(VECS[i]);
            wr_reg(2'd0, v.ma);
            wr_reg(2'd1, {16'h0, v.io});
            wr_reg(2'd2, 24'd1);
            wr_reg(2'd3, {21'd0, v.dec, v.word, 1'b1});
            wr0 = wr_count; dc0 = done_cycles;
            pulse_req(v.src);
            repeat (25) @(negedge clk);
            io_full  = {16'hFFFF, v.io};
            exp_rd   = (v.src == 2'd1) ? io_full : v.ma;
            exp_wr   = (v.src == 2'd1) ? v.ma : io_full;
            exp_data = v.word ? rmodel(exp_rd) : {8'h00, rmodel(exp_rd)[7:0]};
            chk("R4/R5 read address", last_rd_addr, exp_rd);
            chk("R4/R5 write address", last_wr_addr, exp_wr);
            chk("R1 write data", last_wr_data, exp_data);
            chk("R1 one write per request", wr_count - wr0, 1);
            chk("R2 memory address step", mem_addr, v.nxt);
            chk("R6 enable cleared", ch_en, 0);
            chk("R6 done one cycle", done_cycles - dc0, 1);
        end

        // R3: transfers leave the peripheral address fixed
        wr_reg(2'd0, 24'h000500);
        wr_reg(2'd1, 24'h000077);
        wr_reg(2'd2, 24'd2);
        wr_reg(2'd3, 24'h000001);
        pulse_req(2'd0);
        repeat (25) @(negedge clk);
        pulse_req(2'd2);
        repeat (25) @(negedge clk);
        chk("R3 io address unchanged", last_wr_addr, 24'hFFFF77);
        chk("R6 remaining reaches zero", remaining, 0);
        chk("R6 enable off at zero", ch_en, 0);
        // R7: request after count exhausted is ignored
        wr0 = wr_count;
        pulse_req(2'd0);
        repeat (25) @(negedge clk);
        chk("R7 no transfer after end", wr_count - wr0, 0);
        chk("R7 address unchanged after end", mem_addr, 24'h000502);

        // R7: disabled channel ignores requests
        wr_reg(2'd2, 24'd5);
        wr_reg(2'd3, 24'h000000);
        wr0 = wr_count;
        pulse_req(2'd1);
        repeat (25) @(negedge clk);
        chk("R7 disabled no transfer", wr_count - wr0, 0);
        chk("R7 disabled count kept", remaining, 5);

        // R8: one pending request held, the extra dropped
        wr_reg(2'd0, 24'h000600);
        wr_reg(2'd2, 24'd3);
        wr_reg(2'd3, 24'h000001);
        wr0 = wr_count;
        pulse_req(2'd0);
        pulse_req(2'd2);
        pulse_req(2'd3);
        repeat (40) @(negedge clk);
        chk("R8 pending serviced once", wr_count - wr0, 2);
        chk("R8 remaining after two", remaining, 1);
        chk("R8 channel still enabled", ch_en, 1);

        // R10: odd word address
        wr_reg(2'd0, 24'h000101);
        wr_reg(2'd2, 24'd2);
        wr_reg(2'd3, 24'h000003);
        wr0 = wr_count;
        pulse_req(2'd0);
        repeat (25) @(negedge clk);
        chk("R10 err set", err, 1);
        chk("R10 no transfer", wr_count - wr0, 0);
        chk("R10 count kept", remaining, 2);
        chk("R10 address kept", mem_addr, 24'h000101);
        wr_reg(2'd3, 24'h000000);
        chk("R10 err cleared by control write", err, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule